// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one pointer motion event into the five-byte packet used by a three-button serial mouse, and queues those bytes in a small output FIFO. The FIFO feeds a serial receive path, which drains it one byte at a time. An event carries a signed horizontal delta, a signed vertical delta and the state of the left, middle and right buttons.

The first byte of the packet is a start byte. Each button is active low in this byte, so a pressed button shows as 0. The second byte is the horizontal delta, saturated to a symmetric signed byte range. The third byte is the vertical delta with its sign flipped and saturated the same way. Two zero bytes close the packet.

An event is taken only when the encoder is idle and the FIFO has room for a whole packet. Otherwise the busy output is high and the event is not taken. The reader pulls bytes with a read strobe. A data-available flag stays high while any byte is queued.

Top module: `mouse_pkt_encoder`

## Requirements
- R1: Byte 0 of a packet is {5'b10000, ~left, ~middle, ~right}. It equals 0x87 with no button pressed. The left button clears bit 2, the middle button clears bit 1 and the right button clears bit 0.
- R2: Byte 1 is the horizontal delta in two's complement, saturated to -127..+127. An input of -128 or below gives 0x81, and +128 or above gives 0x7F.
- R3: Byte 2 is the negated vertical delta in two's complement, saturated to -127..+127. An input of -512 gives 0x7F.
- R4: Bytes 3 and 4 of every packet are 0x00.
- R5: When an event is taken at clock edge N, its bytes enter the FIFO in packet order, one byte at each of edges N+1 through N+5. The busy output is high from edge N until edge N+5.
- R6: An event is taken only when evt_valid is high and evt_busy is low. evt_busy is also high whenever fewer than five FIFO entries are free. An event presented while busy is high is dropped and adds no bytes.
- R7: A read strobe at an edge loads rd_data with the oldest queued byte, or with 0x00 if the FIFO is empty. rd_data holds its value while rd_en is low.
- R8: data_avail is high exactly while at least one byte is queued. Bytes leave the FIFO in the order they entered.
- R9: A write into a full FIFO is discarded. The fill level never exceeds the FIFO depth (16 by default).
- R10: After reset the FIFO is empty, and data_avail, evt_busy and rd_data are all 0. A reset during packet emission abandons the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Motion event present |
| evt_dx | input | 10 | Horizontal delta, signed |
| evt_dy | input | 10 | Vertical delta, signed |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| evt_busy | output | 1 | Event cannot be taken this cycle |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Byte returned by the last read |
| data_avail | output | 1 | FIFO holds at least one byte |

## Verification
An event taken at edge N raises busy right after that edge. data_avail rises one edge later, at N+1, and the fifth byte is queued at N+5. A read strobe at an edge shows its byte on rd_data right after that same edge. The bench drives inputs on falling edges and samples on the next falling edge. It checks data_avail just after acceptance and again one edge later to confirm the push cadence. It reads a packet only after five further edges have passed. Busy and refusal are checked at fill levels just below and just above the five-free threshold.

// File: rtl/mpk_pkg.sv
package mpk_pkg;
  localparam int PKT_LEN  = 5;
  localparam int BYTE_W   = 8;
  localparam int DELTA_LIM = 127;
  localparam logic [BYTE_W-1:0] START_BASE = 8'h87;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [PKT_LEN-1:0] pkt_t;
endpackage

// File: rtl/mpk_packer.sv
module mpk_packer
  import mpk_pkg::*;
#(
  parameter int DELTA_W = 10
) (
  input  logic [DELTA_W-1:0] dx,
  input  logic [DELTA_W-1:0] dy,
  input  logic               b_left,
  input  logic               b_mid,
  input  logic               b_right,
  output pkt_t               pkt
);
  localparam int EXT_W = DELTA_W + 1;
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'(DELTA_LIM);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [EXT_W-1:0] dx_ext;
  logic signed [EXT_W-1:0] dy_neg;
  byte_t                   dx_byte;
  byte_t                   dy_byte;

  // one extra bit so that negating the most negative input cannot wrap
  always_comb begin
    dx_ext = signed'({dx[DELTA_W-1], dx});
    dy_neg = -signed'({dy[DELTA_W-1], dy});
  end

  always_comb begin
    if (dx_ext > POS_LIM)      dx_byte = POS_LIM[BYTE_W-1:0];
    else if (dx_ext < NEG_LIM) dx_byte = NEG_LIM[BYTE_W-1:0];
    else                       dx_byte = dx_ext[BYTE_W-1:0];
  end

  always_comb begin
    if (dy_neg > POS_LIM)      dy_byte = POS_LIM[BYTE_W-1:0];
    else if (dy_neg < NEG_LIM) dy_byte = NEG_LIM[BYTE_W-1:0];
    else                       dy_byte = dy_neg[BYTE_W-1:0];
  end

  always_comb begin
    pkt[0] = START_BASE ^ {5'b00000, b_left, b_mid, b_right};
    pkt[1] = dx_byte;
    pkt[2] = dy_byte;
  end

  // trailing filler bytes
  for (genvar gi = 3; gi < PKT_LEN; gi++) begin : g_tail
    assign pkt[gi] = '0;
  end
endmodule

// File: rtl/mpk_sequencer.sv
module mpk_sequencer
  import mpk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  pkt_t  pkt_in,
  output logic  push,
  output byte_t push_byte,
  output logic  active
);
  localparam int RW = $clog2(PKT_LEN + 1);

  pkt_t          pkt_q, pkt_d;
  logic [RW-1:0] rem_q, rem_d;
  logic          pkt_en;

  always_comb begin
    push      = (rem_q != '0);
    push_byte = pkt_q[0];
    active    = push;
  end

  always_comb begin
    rem_d  = rem_q;
    pkt_d  = pkt_q;
    pkt_en = 1'b0;
    if (load) begin
      rem_d  = RW'(PKT_LEN);
      pkt_d  = pkt_in;
      pkt_en = 1'b1;
    end else if (push) begin
      rem_d  = rem_q - 1'b1;
      pkt_d  = pkt_t'({{BYTE_W{1'b0}}, pkt_q[PKT_LEN-1:1]});
      pkt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pkt_q <= '0;
    else if (pkt_en) pkt_q <= pkt_d;
  end
endmodule

// File: rtl/mpk_fifo.sv
module mpk_fifo
  import mpk_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  byte_t                      wdata,
  input  logic                       rd,
  output byte_t                      rdata,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       not_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  byte_t         mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  byte_t         rdata_q, rdata_d;
  logic          full, empty, wr_ok, rd_ok;

  always_comb begin
    empty = (cnt_q == '0);
    full  = (cnt_q == CW'(DEPTH));
    wr_ok = wr && !full;
    rd_ok = rd && !empty;
  end

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    if (wr_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (rd_ok) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    if (wr_ok && !rd_ok)      cnt_d = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
    if (rd) rdata_d = rd_ok ? mem[rptr_q] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
    end
  end

  // storage array: write-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wdata;
  end

  assign rdata     = rdata_q;
  assign level     = cnt_q;
  assign not_empty = !empty;
endmodule

// File: rtl/mouse_pkt_encoder.sv
module mouse_pkt_encoder
  import mpk_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [DELTA_W-1:0] evt_dx,
  input  logic [DELTA_W-1:0] evt_dy,
  input  logic               btn_left,
  input  logic               btn_mid,
  input  logic               btn_right,
  output logic               evt_busy,
  input  logic               rd_en,
  output logic [7:0]         rd_data,
  output logic               data_avail
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH - PKT_LEN);

  pkt_t          pkt_bytes;
  logic          evt_take;
  logic          seq_push;
  logic          seq_active;
  byte_t         seq_byte;
  logic [CW-1:0] fifo_count;

  always_comb begin
    evt_busy = seq_active || (fifo_count > ROOM_LIMIT);
    evt_take = evt_valid && !evt_busy;
  end

  mpk_packer #(.DELTA_W(DELTA_W)) u_packer (
    .dx      (evt_dx),
    .dy      (evt_dy),
    .b_left  (btn_left),
    .b_mid   (btn_mid),
    .b_right (btn_right),
    .pkt     (pkt_bytes)
  );

  mpk_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (evt_take),
    .pkt_in    (pkt_bytes),
    .push      (seq_push),
    .push_byte (seq_byte),
    .active    (seq_active)
  );

  mpk_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (seq_push),
    .wdata     (seq_byte),
    .rd        (rd_en),
    .rdata     (rd_data),
    .level     (fifo_count),
    .not_empty (data_avail)
  );
endmodule

// File: rtl/mpk_checker.sv
module mpk_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       evt_valid,
  input logic                       evt_busy,
  input logic                       rd_en,
  input logic [7:0]                 rd_data,
  input logic                       data_avail,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  // R5: an accepted event starts pushing on the next edge and holds busy
  p_push_follows_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_busy) |=> (push && evt_busy));

  // R6: no byte enters while nothing was accepted and the sequencer is idle
  p_no_stray_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_busy && !evt_valid) |=> !push);

  // R7: a read strobe on an empty FIFO yields zero
  p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !data_avail) |=> (rd_data == 8'h00));

  // R7: rd_data holds without a read strobe
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R8: available data cannot vanish without a read
  p_avail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_avail && !rd_en) |=> data_avail);

  // R9: fill level never exceeds depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind mouse_pkt_encoder mpk_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_valid  (evt_valid),
  .evt_busy   (evt_busy),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .data_avail (data_avail),
  .push       (seq_push),
  .fill       (fifo_count)
);

// File: tb/mouse_pkt_encoder_test.sv
`timescale 1ns/1ps
module mouse_pkt_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic [9:0] evt_dx = '0;
  logic [9:0] evt_dy = '0;
  logic       btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
  logic       evt_busy;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       data_avail;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mouse_pkt_encoder uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dx(evt_dx),
    .evt_dy(evt_dy), .btn_left(btn_left), .btn_mid(btn_mid),
    .btn_right(btn_right), .evt_busy(evt_busy), .rd_en(rd_en),
    .rd_data(rd_data), .data_avail(data_avail)
  );

  // {dx, dy, left, mid, right, byte0, byte1, byte2}
  localparam int NV = 8;
  localparam logic [46:0] VEC [NV] = '{
    {10'h005, 10'h003, 3'b000, 8'h87, 8'h05, 8'hFD},
    {10'h3FB, 10'h3FD, 3'b100, 8'h83, 8'hFB, 8'h03},
    {10'h0C8, 10'h338, 3'b010, 8'h85, 8'h7F, 8'h7F},
    {10'h338, 10'h0C8, 3'b001, 8'h86, 8'h81, 8'h81},
    {10'h07F, 10'h381, 3'b111, 8'h80, 8'h7F, 8'h7F},
    {10'h200, 10'h200, 3'b101, 8'h82, 8'h81, 8'h7F},
    {10'h380, 10'h080, 3'b000, 8'h87, 8'h81, 8'h81},
    {10'h000, 10'h000, 3'b110, 8'h81, 8'h00, 8'h00}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_evt(input logic [9:0] dx, input logic [9:0] dy,
                          input logic [2:0] btn);
    @(negedge clk);
    evt_dx = dx; evt_dy = dy;
    {btn_left, btn_mid, btn_right} = btn;
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] b);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    b = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    // R10: reset state
    idle(3);
    check(data_avail == 1'b0, "R10 avail after reset", int'(data_avail), 0);
    check(evt_busy == 1'b0, "R10 busy after reset", int'(evt_busy), 0);
    check(rd_data == 8'h00, "R10 rd_data after reset", int'(rd_data), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // vector loop: R1..R5, R8
    for (int v = 0; v < NV; v++) begin
      send_evt(VEC[v][46:37], VEC[v][36:27], VEC[v][26:24]);
      check(evt_busy == 1'b1, "R5 busy right after take", int'(evt_busy), 1);
      check(data_avail == 1'b0, "R5 no byte at take edge", int'(data_avail), 0);
      @(negedge clk);
      check(data_avail == 1'b1, "R5 first byte one edge later", int'(data_avail), 1);
      idle(4);
      check(evt_busy == 1'b0, "R5 busy clears after fifth push", int'(evt_busy), 0);
      read_byte(b);
      check(b == VEC[v][23:16], "R1 start byte", int'(b), int'(VEC[v][23:16]));
      read_byte(b);
      check(b == VEC[v][15:8], "R2 dx byte", int'(b), int'(VEC[v][15:8]));
      read_byte(b);
      check(b == VEC[v][7:0], "R3 dy byte", int'(b), int'(VEC[v][7:0]));
      read_byte(b);
      check(b == 8'h00, "R4 tail byte 3", int'(b), 0);
      check(data_avail == 1'b1, "R8 avail with one left", int'(data_avail), 1);
      read_byte(b);
      check(b == 8'h00, "R4 tail byte 4", int'(b), 0);
      check(data_avail == 1'b0, "R8 avail drops when empty", int'(data_avail), 0);
    end

    // R7: empty read returns zero
    read_byte(b);
    check(b == 8'h00, "R7 empty read", int'(b), 0);

    // R6: fill to 15, busy on shortage of room, refused event adds nothing
    send_evt(10'h001, 10'h000, 3'b000); idle(5);
    send_evt(10'h002, 10'h000, 3'b000); idle(5);
    check(evt_busy == 1'b0, "R6 ten queued still has room", int'(evt_busy), 0);
    send_evt(10'h003, 10'h000, 3'b000); idle(5);
    check(evt_busy == 1'b1, "R6 busy with one free", int'(evt_busy), 1);
    send_evt(10'h04A, 10'h000, 3'b000); idle(5);
    read_byte(b);
    check(b == 8'h87, "R8 order first byte", int'(b), 8'h87);
    read_byte(b);
    check(b == 8'h01, "R8 order dx of first packet", int'(b), 1);
    for (int i = 0; i < 9; i++) read_byte(b);
    check(evt_busy == 1'b0, "R6 room restored at four queued", int'(evt_busy), 0);
    read_byte(b);
    check(b == 8'h03, "R8 third packet dx", int'(b), 3);
    for (int i = 0; i < 3; i++) read_byte(b);
    check(data_avail == 1'b0, "R6 refused event added no bytes", int'(data_avail), 0);

    // R10: reset during emission abandons packet
    send_evt(10'h010, 10'h000, 3'b000);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(6);
    check(data_avail == 1'b0, "R10 reset mid-packet empties", int'(data_avail), 0);
    check(evt_busy == 1'b0, "R10 reset mid-packet idle", int'(evt_busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule